// File: doc/BRIEF.md
# Message Interface Transfer Engine

This block sits between a host-facing staging buffer and a bank of 32 stored message objects. The host fills the staging buffer (acceptance-mask word, arbitration word, control word and two data words), loads an 8-bit command mask, and then writes a message number to the request address. That request starts a fixed four-cycle transfer. The direction and the parts that move come from the command mask. While the transfer runs, a busy flag is high and every host write is dropped.

A write transfer copies the selected buffer parts into the addressed object and can also raise that object's transmit-request flag. A read transfer copies the selected object parts into the buffer. It can also clear the object's interrupt-pending and new-data flags, and the buffer receives the control word as it was before the clear. Four 32-bit vectors expose the transmit-request, new-data, interrupt-pending and valid flags of all objects at once. Bit n-1 of each vector belongs to object n.

Top module: `msg_xfer_engine`

## Requirements
- R1: A host write to the request address (host_addr 1) while idle raises busy after that edge. Busy stays high for exactly four clock edges, one each for the mask, arbitration, control and data phases, and is low after the fourth.
- R2: The message number is request data bits 5..0. Values 1..32 select object n, 0 selects object 32, and 33..63 select objects 1..31 (n-32).
- R3: Command mask bit 7 sets the direction: 0 copies buffer to object, 1 copies object to buffer.
- R4: Command mask bits 6, 5, 4, 1 and 0 select the mask word, the arbitration word, the control word, data word A and data word B. Parts that are not selected are left unchanged on both sides.
- R5: On a write transfer, command bit 2 sets bit 8 (transmit request) of the object's control word, after any control copy. Command bit 3 has no effect.
- R6: On a read transfer, command bit 3 clears control bit 13 (interrupt pending) and command bit 2 clears control bit 15 (new data) in the object. When the control word is selected, the buffer receives the value from before the clear.
- R7: While busy is high, all host writes are ignored, including cmd mask (addr 0), buffer words (addrs 2..6) and new requests.
- R8: txrqst_vec, newdat_vec and intpnd_vec bit n-1 equal control bits 8, 15 and 13 of object n. msgval_vec bit n-1 equals bit 31 of object n's arbitration word.
- R9: After reset, busy, every buffer word and every object flag vector read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | 0 cmd mask, 1 request, 2 mask, 3 arbitration, 4 control, 5 data A, 6 data B |
| host_wdata | input | 32 | Host write data |
| busy | output | 1 | Transfer in progress |
| mask_out | output | 32 | Buffer mask word |
| arb_out | output | 32 | Buffer arbitration word (bit 31 valid) |
| ctrl_out | output | 16 | Buffer control word |
| data_a_out | output | 32 | Buffer data word A |
| data_b_out | output | 32 | Buffer data word B |
| txrqst_vec | output | 32 | Transmit-request flags of all objects |
| newdat_vec | output | 32 | New-data flags of all objects |
| intpnd_vec | output | 32 | Interrupt-pending flags of all objects |
| msgval_vec | output | 32 | Valid flags of all objects |

## Verification
The bench uses the message numbers 0, 32, 33 and 63. A design that folds them wrongly stores data in one object and reads it back from another. It issues a write with bit 3 set and reads that clear only one flag at a time. These cases expose a design that clears the interrupt-pending flag on writes, clears both flags together, or returns the control word after the clear. Every transfer is also hit with a data write and a second request while busy. A design that accepts either one corrupts the buffer or stretches busy past four cycles. Random command masks then test each part and its unselected neighbours together.

// File: rtl/msgx_pkg.sv
package msgx_pkg;
    localparam int WORD_W = 32;
    localparam int CTRL_W = 16;
    localparam int CMD_W  = 8;
    localparam int NUM_W  = 6;
    localparam int ADDR_W = 3;

    // command mask bit positions
    localparam int CM_DIR    = 7;
    localparam int CM_MASK   = 6;
    localparam int CM_ARB    = 5;
    localparam int CM_CTRL   = 4;
    localparam int CM_INTCLR = 3;
    localparam int CM_TXNEW  = 2;
    localparam int CM_DA     = 1;
    localparam int CM_DB     = 0;

    // control word bit positions
    localparam int CB_NEWDAT = 15;
    localparam int CB_INTPND = 13;
    localparam int CB_TXRQST = 8;
    localparam int AB_VALID  = 31;

    // host address codes
    localparam logic [ADDR_W-1:0] HA_CMD  = 3'd0;
    localparam logic [ADDR_W-1:0] HA_REQ  = 3'd1;
    localparam logic [ADDR_W-1:0] HA_MASK = 3'd2;
    localparam logic [ADDR_W-1:0] HA_ARB  = 3'd3;
    localparam logic [ADDR_W-1:0] HA_CTRL = 3'd4;
    localparam logic [ADDR_W-1:0] HA_DA   = 3'd5;
    localparam logic [ADDR_W-1:0] HA_DB   = 3'd6;

    typedef enum logic [1:0] {PH_MASK, PH_ARB, PH_CTRL, PH_DATA} phase_e;

    typedef struct packed {
        logic [WORD_W-1:0] mask;
        logic [WORD_W-1:0] arb;
        logic [CTRL_W-1:0] ctrl;
        logic [WORD_W-1:0] da;
        logic [WORD_W-1:0] db;
    } obj_t;
endpackage

// File: rtl/msgx_seq.sv
module msgx_seq
    import msgx_pkg::*;
#(
    parameter int NUM_OBJ = 32,
    localparam int IDX_W = $clog2(NUM_OBJ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CMD_W-1:0] cmd_in,
    input  logic [NUM_W-1:0] num_in,
    output logic             busy,
    output phase_e           phase,
    output logic [CMD_W-1:0] cmd,
    output logic [IDX_W-1:0] idx
);
    localparam int WRAP = 2 ** NUM_W;

    typedef struct packed {
        logic             busy;
        phase_e           phase;
        logic [CMD_W-1:0] cmd;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t s_d, s_q;
    logic [IDX_W-1:0] idx_fold;

    // number n maps to object ((n-1) mod NUM_OBJ); 0 wraps to the last one
    assign idx_fold = IDX_W'((int'(num_in) + WRAP - 1) % NUM_OBJ);

    always_comb begin
        s_d = s_q;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy  = 1'b1;
                s_d.phase = PH_MASK;
                s_d.cmd   = cmd_in;
                s_d.idx   = idx_fold;
            end
        end else if (s_q.phase == PH_DATA) begin
            s_d.busy = 1'b0;
        end else begin
            s_d.phase = phase_e'(s_q.phase + 2'd1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy  = s_q.busy;
    assign phase = s_q.phase;
    assign cmd   = s_q.cmd;
    assign idx   = s_q.idx;

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && phase == PH_MASK)); // R1
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase != PH_DATA) |=> (busy && phase == phase_e'($past(phase) + 2'd1))); // R1
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase == PH_DATA) |=> !busy); // R1
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase != PH_DATA) |=> $stable(cmd) && $stable(idx)); // R7
endmodule

// File: rtl/msgx_store.sv
module msgx_store
    import msgx_pkg::*;
#(
    parameter int NUM_OBJ = 32,
    localparam int IDX_W = $clog2(NUM_OBJ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   idx,
    input  logic               we_mask,
    input  logic               we_arb,
    input  logic               we_ctrl,
    input  logic               we_da,
    input  logic               we_db,
    input  logic               set_txrqst,
    input  logic               clr_intpnd,
    input  logic               clr_newdat,
    input  obj_t               wr_obj,
    output obj_t               rd_obj,
    output logic [NUM_OBJ-1:0] txrqst_vec,
    output logic [NUM_OBJ-1:0] newdat_vec,
    output logic [NUM_OBJ-1:0] intpnd_vec,
    output logic [NUM_OBJ-1:0] msgval_vec
);
    obj_t ent_q [NUM_OBJ];

    for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
        obj_t ent_d;
        always_comb begin
            ent_d = ent_q[g];
            if (idx == IDX_W'(g)) begin
                if (we_mask) ent_d.mask = wr_obj.mask;
                if (we_arb)  ent_d.arb  = wr_obj.arb;
                if (we_ctrl) ent_d.ctrl = wr_obj.ctrl;
                if (we_da)   ent_d.da   = wr_obj.da;
                if (we_db)   ent_d.db   = wr_obj.db;
                if (set_txrqst) ent_d.ctrl[CB_TXRQST] = 1'b1;
                if (clr_intpnd) ent_d.ctrl[CB_INTPND] = 1'b0;
                if (clr_newdat) ent_d.ctrl[CB_NEWDAT] = 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q[g] <= '0;
            else        ent_q[g] <= ent_d;
        end

        assign txrqst_vec[g] = ent_q[g].ctrl[CB_TXRQST];
        assign newdat_vec[g] = ent_q[g].ctrl[CB_NEWDAT];
        assign intpnd_vec[g] = ent_q[g].ctrl[CB_INTPND];
        assign msgval_vec[g] = ent_q[g].arb[AB_VALID];
    end

    assign rd_obj = ent_q[idx];

    AST_TXRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_txrqst |=> txrqst_vec[$past(idx)]); // R5
    AST_INTPND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_intpnd |=> !intpnd_vec[$past(idx)]); // R6
    AST_NEWDAT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_newdat |=> !newdat_vec[$past(idx)]); // R6
endmodule

// File: rtl/msg_xfer_engine.sv
module msg_xfer_engine
    import msgx_pkg::*;
#(
    parameter int NUM_OBJ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [2:0]         host_addr,
    input  logic [31:0]        host_wdata,
    output logic               busy,
    output logic [31:0]        mask_out,
    output logic [31:0]        arb_out,
    output logic [15:0]        ctrl_out,
    output logic [31:0]        data_a_out,
    output logic [31:0]        data_b_out,
    output logic [NUM_OBJ-1:0] txrqst_vec,
    output logic [NUM_OBJ-1:0] newdat_vec,
    output logic [NUM_OBJ-1:0] intpnd_vec,
    output logic [NUM_OBJ-1:0] msgval_vec
);
    localparam int IDX_W = $clog2(NUM_OBJ);

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        obj_t             obj;
    } buf_t;

    buf_t             buf_d, buf_q;
    phase_e           phase;
    logic [CMD_W-1:0] xcmd;
    logic [IDX_W-1:0] idx;
    logic             start, rd_dir;
    logic             we_mask, we_arb, we_ctrl, we_da, we_db;
    logic             set_txrqst, clr_intpnd, clr_newdat;
    obj_t             rd_obj;

    assign start  = host_we && (host_addr == HA_REQ) && !busy;
    assign rd_dir = xcmd[CM_DIR];

    msgx_seq #(.NUM_OBJ(NUM_OBJ)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .cmd_in (buf_q.cmd),
        .num_in (host_wdata[NUM_W-1:0]),
        .busy   (busy),
        .phase  (phase),
        .cmd    (xcmd),
        .idx    (idx)
    );

    // phase strobes toward the object store
    always_comb begin
        we_mask = 1'b0; we_arb = 1'b0; we_ctrl = 1'b0; we_da = 1'b0; we_db = 1'b0;
        set_txrqst = 1'b0; clr_intpnd = 1'b0; clr_newdat = 1'b0;
        if (busy) begin
            case (phase)
                PH_MASK: we_mask = !rd_dir && xcmd[CM_MASK];
                PH_ARB:  we_arb  = !rd_dir && xcmd[CM_ARB];
                PH_CTRL: begin
                    we_ctrl    = !rd_dir && xcmd[CM_CTRL];
                    set_txrqst = !rd_dir && xcmd[CM_TXNEW];
                    clr_intpnd =  rd_dir && xcmd[CM_INTCLR];
                    clr_newdat =  rd_dir && xcmd[CM_TXNEW];
                end
                PH_DATA: begin
                    we_da = !rd_dir && xcmd[CM_DA];
                    we_db = !rd_dir && xcmd[CM_DB];
                end
                default: ;
            endcase
        end
    end

    msgx_store #(.NUM_OBJ(NUM_OBJ)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (idx),
        .we_mask    (we_mask),
        .we_arb     (we_arb),
        .we_ctrl    (we_ctrl),
        .we_da      (we_da),
        .we_db      (we_db),
        .set_txrqst (set_txrqst),
        .clr_intpnd (clr_intpnd),
        .clr_newdat (clr_newdat),
        .wr_obj     (buf_q.obj),
        .rd_obj     (rd_obj),
        .txrqst_vec (txrqst_vec),
        .newdat_vec (newdat_vec),
        .intpnd_vec (intpnd_vec),
        .msgval_vec (msgval_vec)
    );

    // staging buffer: host writes when idle, object reads when busy
    always_comb begin
        buf_d = buf_q;
        if (!busy) begin
            if (host_we) begin
                case (host_addr)
                    HA_CMD:  buf_d.cmd      = host_wdata[CMD_W-1:0];
                    HA_MASK: buf_d.obj.mask = host_wdata;
                    HA_ARB:  buf_d.obj.arb  = host_wdata;
                    HA_CTRL: buf_d.obj.ctrl = host_wdata[CTRL_W-1:0];
                    HA_DA:   buf_d.obj.da   = host_wdata;
                    HA_DB:   buf_d.obj.db   = host_wdata;
                    default: ;
                endcase
            end
        end else if (rd_dir) begin
            case (phase)
                PH_MASK: if (xcmd[CM_MASK]) buf_d.obj.mask = rd_obj.mask;
                PH_ARB:  if (xcmd[CM_ARB])  buf_d.obj.arb  = rd_obj.arb;
                PH_CTRL: if (xcmd[CM_CTRL]) buf_d.obj.ctrl = rd_obj.ctrl;
                PH_DATA: begin
                    if (xcmd[CM_DA]) buf_d.obj.da = rd_obj.da;
                    if (xcmd[CM_DB]) buf_d.obj.db = rd_obj.db;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign mask_out   = buf_q.obj.mask;
    assign arb_out    = buf_q.obj.arb;
    assign ctrl_out   = buf_q.obj.ctrl;
    assign data_a_out = buf_q.obj.da;
    assign data_b_out = buf_q.obj.db;

    AST_IDLE_STORE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(txrqst_vec) && $stable(newdat_vec)
                   && $stable(intpnd_vec) && $stable(msgval_vec))); // R7
    AST_WRITE_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_dir) |=> ($stable(mask_out) && $stable(arb_out) && $stable(ctrl_out)
                               && $stable(data_a_out) && $stable(data_b_out))); // R3
    AST_READ_KEEPS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_dir) |=> ($stable(txrqst_vec) && $stable(msgval_vec))); // R3
endmodule

// File: tb/msg_xfer_engine_test.sv
module msg_xfer_engine_test;
    import msgx_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        busy;
    logic [31:0] mask_out, arb_out, data_a_out, data_b_out;
    logic [15:0] ctrl_out;
    logic [31:0] txrqst_vec, newdat_vec, intpnd_vec, msgval_vec;

    always #4 clk = ~clk;

    msg_xfer_engine uut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .busy(busy), .mask_out(mask_out), .arb_out(arb_out),
        .ctrl_out(ctrl_out), .data_a_out(data_a_out), .data_b_out(data_b_out),
        .txrqst_vec(txrqst_vec), .newdat_vec(newdat_vec), .intpnd_vec(intpnd_vec),
        .msgval_vec(msgval_vec)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference model
    logic [31:0] m_mask [32];
    logic [31:0] m_arb  [32];
    logic [15:0] m_ctrl [32];
    logic [31:0] m_da   [32];
    logic [31:0] m_db   [32];
    logic [7:0]  b_cmd;
    logic [31:0] b_mask, b_arb, b_da, b_db;
    logic [15:0] b_ctrl;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic int fold(int num);
        if (num == 0) return 31;
        if (num > 32) return num - 33;
        return num - 1;
    endfunction

    function automatic logic [31:0] vec_of(int which);
        logic [31:0] v;
        for (int i = 0; i < 32; i++) begin
            case (which)
                0: v[i] = m_ctrl[i][8];
                1: v[i] = m_ctrl[i][15];
                2: v[i] = m_ctrl[i][13];
                default: v[i] = m_arb[i][31];
            endcase
        end
        return v;
    endfunction

    task automatic hwr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        case (a)
            HA_CMD:  b_cmd  = d[7:0];
            HA_MASK: b_mask = d;
            HA_ARB:  b_arb  = d;
            HA_CTRL: b_ctrl = d[15:0];
            HA_DA:   b_da   = d;
            HA_DB:   b_db   = d;
            default: ;
        endcase
    endtask

    task automatic model_xfer(int num);
        int i = fold(num);
        if (!b_cmd[7]) begin
            if (b_cmd[6]) m_mask[i] = b_mask;
            if (b_cmd[5]) m_arb[i]  = b_arb;
            if (b_cmd[4]) m_ctrl[i] = b_ctrl;
            if (b_cmd[2]) m_ctrl[i][8] = 1'b1;
            if (b_cmd[1]) m_da[i] = b_da;
            if (b_cmd[0]) m_db[i] = b_db;
        end else begin
            if (b_cmd[6]) b_mask = m_mask[i];
            if (b_cmd[5]) b_arb  = m_arb[i];
            if (b_cmd[4]) b_ctrl = m_ctrl[i];
            if (b_cmd[3]) m_ctrl[i][13] = 1'b0;
            if (b_cmd[2]) m_ctrl[i][15] = 1'b0;
            if (b_cmd[1]) b_da = m_da[i];
            if (b_cmd[0]) b_db = m_db[i];
        end
    endtask

    task automatic compare_all();
        chk("R4 mask_out", mask_out, b_mask);
        chk("R4 arb_out", arb_out, b_arb);
        chk("R6 ctrl_out", {16'h0, ctrl_out}, {16'h0, b_ctrl});
        chk("R4 data_a_out", data_a_out, b_da);
        chk("R4 data_b_out", data_b_out, b_db);
        chk("R5 txrqst_vec", txrqst_vec, vec_of(0));
        chk("R6 newdat_vec", newdat_vec, vec_of(1));
        chk("R6 intpnd_vec", intpnd_vec, vec_of(2));
        chk("R8 msgval_vec", msgval_vec, vec_of(3));
    endtask

    // request at edge E; junk writes during busy must be dropped (R7)
    task automatic xfer(int num);
        @(negedge clk);
        host_we = 1'b1; host_addr = HA_REQ; host_wdata = 32'(num);
        @(negedge clk);
        chk("R1 busy after request", {31'h0, busy}, 32'h1);
        host_addr = HA_DA; host_wdata = ~b_da;
        @(negedge clk);
        chk("R7 data A write ignored", data_a_out, b_da);
        host_addr = HA_REQ; host_wdata = 32'(num ^ 5);
        @(negedge clk);
        host_we = 1'b0;
        @(negedge clk);
        chk("R1 busy in fourth cycle", {31'h0, busy}, 32'h1);
        @(negedge clk);
        chk("R1 busy clear after four", {31'h0, busy}, 32'h0);
        model_xfer(num);
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        for (int i = 0; i < 32; i++) begin
            m_mask[i] = '0; m_arb[i] = '0; m_ctrl[i] = '0; m_da[i] = '0; m_db[i] = '0;
        end
        b_cmd = '0; b_mask = '0; b_arb = '0; b_ctrl = '0; b_da = '0; b_db = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 busy", {31'h0, busy}, 32'h0);
        chk("R9 data_a", data_a_out, 32'h0);
        chk("R9 ctrl", {16'h0, ctrl_out}, 32'h0);
        chk("R9 txrqst", txrqst_vec, 32'h0);
        chk("R9 msgval", msgval_vec, 32'h0);

        // R2 folding: 0 is object 32, 33 is object 1, 63 is object 31
        hwr(HA_DA, 32'hA5A5_0032); hwr(HA_CMD, 32'h02); xfer(0);
        hwr(HA_DA, 32'h0); hwr(HA_CMD, 32'h82); xfer(32);
        chk("R2 number 0 reaches object 32", data_a_out, 32'hA5A5_0032);
        hwr(HA_DA, 32'h1111_0001); hwr(HA_CMD, 32'h02); xfer(33);
        hwr(HA_DA, 32'h0); hwr(HA_CMD, 32'h82); xfer(1);
        chk("R2 number 33 reaches object 1", data_a_out, 32'h1111_0001);
        hwr(HA_DB, 32'h3131_0031); hwr(HA_CMD, 32'h01); xfer(63);
        hwr(HA_DB, 32'h0); hwr(HA_CMD, 32'h81); xfer(31);
        chk("R2 number 63 reaches object 31", data_b_out, 32'h3131_0031);

        // R3 direction and R8 valid flag
        hwr(HA_ARB, 32'h8000_0123); hwr(HA_CTRL, 32'h0100); hwr(HA_CMD, 32'h30); xfer(5);
        chk("R3 write stored txrqst", {31'h0, txrqst_vec[4]}, 32'h1);
        chk("R8 msgval bit 4", {31'h0, msgval_vec[4]}, 32'h1);
        hwr(HA_CTRL, 32'h0); hwr(HA_ARB, 32'h0); hwr(HA_CMD, 32'hB0); xfer(5);
        chk("R3 read returns control", {16'h0, ctrl_out}, 32'h0100);
        chk("R3 read returns arb", arb_out, 32'h8000_0123);

        // R5: bit 3 ignored on write, bit 2 sets txrqst
        hwr(HA_CTRL, 32'hA000); hwr(HA_CMD, 32'h10); xfer(7);
        hwr(HA_CMD, 32'h0C); xfer(7);
        chk("R5 intpnd kept on write", {31'h0, intpnd_vec[6]}, 32'h1);
        chk("R5 txrqst set on write", {31'h0, txrqst_vec[6]}, 32'h1);

        // R6: clear intpnd only, pre-clear value returned
        hwr(HA_CMD, 32'h98); xfer(7);
        chk("R6 pre-clear control", {16'h0, ctrl_out}, 32'hA100);
        chk("R6 intpnd cleared", {31'h0, intpnd_vec[6]}, 32'h0);
        chk("R6 newdat kept", {31'h0, newdat_vec[6]}, 32'h1);
        hwr(HA_CMD, 32'h84); xfer(7);
        chk("R6 newdat cleared", {31'h0, newdat_vec[6]}, 32'h0);

        // random traffic
        for (int it = 0; it < 150; it++) begin
            if ($urandom_range(1)) hwr(HA_MASK, $urandom);
            if ($urandom_range(1)) hwr(HA_ARB, $urandom);
            if ($urandom_range(1)) hwr(HA_CTRL, $urandom);
            if ($urandom_range(1)) hwr(HA_DA, $urandom);
            if ($urandom_range(1)) hwr(HA_DB, $urandom);
            hwr(HA_CMD, $urandom);
            xfer(int'($urandom_range(63)));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule